// File: doc/BRIEF.md
# Two-Class Vectored Interrupt Controller

This block gathers up to 32 interrupt lines and presents them to a processor as two request wires. One wire is for ordinary requests and one is for urgent ones. Software sets up each line through a small register bus with a 4-bit word address, separate read and write strobes and 32-bit data. For each line it chooses whether the line is active high or active low, whether it is latched on an edge or followed as a level, whether it may raise a request at all, and which of the two wires it drives.

For the urgent class the block also provides a ready-made handler address. A programmable base is combined with a fixed 512-byte stride for each priority position. The position is found by scanning the pending urgent sources, either from line 0 upward or from the top line downward. The scan direction is a configuration bit. The vector logic can be removed by a parameter; its two registers then read as zero.

Both request wires and the vector are registered. A change of configuration reaches them one clock later. An input change needs one clock to reach the status register and one more to reach the outputs.

Top module: `crit_vec_intc`

## Requirements
- R1: After reset every register reads 0 and both request outputs are low, so all lines start active low, level mode, ordinary class and masked.
- R2: Polarity register (offset 4): bit value 1 makes the line active high, and bit value 0 makes it active low (the pin is inverted before use).
- R3: Trigger register (offset 5) bit 1 selects edge mode. An inactive-to-active transition sets the status bit, the bit stays set after the line falls, and only a write-1-to-clear removes it. A clear while the line is still held active is not undone until a new transition occurs.
- R4: With a trigger bit of 0 (level mode), the status bit equals the polarity-adjusted input seen at the previous clock edge.
- R5: A write to offset 0 clears the status bits written as 1. A write to offset 1 sets them. Reads of either offset return the status register.
- R6: irq_norm goes high when any bit of status AND enable (offset 2) AND NOT class (offset 3) is set. irq_crit goes high when any bit of status AND enable AND class is set. Both follow the register state with exactly one cycle of latency.
- R7: Offset 6 reads status AND enable. Writes to offset 6 and offset 7 change nothing.
- R8: With vector configuration (offset 8) bit 0 clear, the vector (offset 7) reads the configuration with its two low bits cleared, plus 512 times the index of the lowest-numbered pending critical line.
- R9: With vector configuration bit 0 set, the scan starts at line 31. The vector is the cleared base plus 512 times (31 minus the index of the highest-numbered pending critical line).
- R10: The vector reads 0 whenever no enabled critical line is pending, whatever the base.
- R11: A write to offset 8 stores the data with bit 1 forced to 0.
- R12: Reads of the unused offsets 9 to 15 return 0, and writes to them change nothing.
- R13: When an edge-mode line rises in the same cycle that software clears its status bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt lines, already synchronous to clk |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; rd_data is zero while low |
| rd_data | output | DATA_W | Read data, combinational from addr |
| irq_norm | output | 1 | Ordinary-class request |
| irq_crit | output | 1 | Urgent-class request |

## Verification
The bench clears an edge-latched line while its pin is still held active. A design that re-latched on level would set the bit again. It also drives a rising edge on the same cycle as a software clear; a design that gave the clear priority would lose that interrupt. The vector is checked at both ends of both scan directions and with ordinary and urgent lines pending together. An off-by-one in the downward step count, or a scan that included ordinary-class lines, would produce a wrong handler address. The one-cycle output latency, the ignored writes to the derived registers and the forced-zero configuration bit are each observed directly at the ports.

// File: rtl/cvi_pkg.sv
`timescale 1ns/1ps
package cvi_pkg;
   // Register word offsets decoded on the bus
   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      OFS_STAT   = 4'd0,
      OFS_STSET  = 4'd1,
      OFS_ENA    = 4'd2,
      OFS_CLASS  = 4'd3,
      OFS_POL    = 4'd4,
      OFS_TRIG   = 4'd5,
      OFS_MASKED = 4'd6,
      OFS_VEC    = 4'd7,
      OFS_VCFG   = 4'd8
   } cvi_ofs_e;

   // Vector configuration bit meanings
   localparam int unsigned VCFG_DIR_BIT  = 0;
   localparam int unsigned VCFG_ZERO_BIT = 1;
endpackage

// File: rtl/cvi_src_cond.sv
`timescale 1ns/1ps
// Polarity adjustment and rising-edge detection per source line
module cvi_src_cond #(
   parameter int unsigned N = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_raw,
   input  logic [N-1:0] pol,
   output logic [N-1:0] act,
   output logic [N-1:0] rise
);
   // Raw pin history; the current polarity is applied to both samples so
   // that a polarity change alone never looks like an edge.
   logic [N-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= irq_raw;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic act_prev;
      assign act[i]   = pol[i] ? irq_raw[i] : ~irq_raw[i];
      assign act_prev = pol[i] ? raw_q[i]   : ~raw_q[i];
      assign rise[i]  = act[i] & ~act_prev;
   end
endmodule

// File: rtl/cvi_status.sv
`timescale 1ns/1ps
// Status register: level lines track the pin, edge lines latch
module cvi_status #(
   parameter int unsigned N = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] act,
   input  logic [N-1:0] rise,
   input  logic [N-1:0] trig,
   input  logic [N-1:0] sw_clr,
   input  logic [N-1:0] sw_set,
   output logic [N-1:0] st_q
);
   logic [N-1:0] st_d;

   for (genvar i = 0; i < N; i++) begin : g_bit
      // Hardware set is ORed in after the clear, so it wins a same-cycle race
      assign st_d[i] = trig[i] ? ((st_q[i] & ~sw_clr[i]) | sw_set[i] | rise[i])
                               : act[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/cvi_vector.sv
`timescale 1ns/1ps
// Critical-source priority scan and handler address generation
module cvi_vector #(
   parameter int unsigned N     = 32,
   parameter int unsigned W     = 32,
   parameter int unsigned SHIFT = 9,
   parameter bit          EN    = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] crit,
   input  logic [W-1:0] cfg,
   output logic [W-1:0] vec_q
);
   import cvi_pkg::*;

   localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

   if (EN) begin : g_vec
      logic [N-1:0]  ord;
      logic [SW-1:0] steps;
      logic          hit;
      logic [W-1:0]  base;
      logic [W-1:0]  vec_d;

      // Reorder so that scan position 0 is always the first line examined
      for (genvar i = 0; i < N; i++) begin : g_ord
         assign ord[i] = cfg[VCFG_DIR_BIT] ? crit[N-1-i] : crit[i];
      end

      assign base = cfg & ~W'(3);

      always_comb begin
         steps = '0;
         hit   = 1'b0;
         for (int i = N - 1; i >= 0; i--) begin
            if (ord[i]) begin
               steps = SW'(i);
               hit   = 1'b1;
            end
         end
         vec_d = hit ? (base + (W'(steps) << SHIFT)) : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vec_q <= '0;
         else        vec_q <= vec_d;
      end
   end else begin : g_novec
      assign vec_q = '0;
   end
endmodule

// File: rtl/crit_vec_intc.sv
`timescale 1ns/1ps
// Two-class interrupt controller with optional critical vector
module crit_vec_intc
   import cvi_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned VEC_SHIFT = 9,
   parameter bit          VEC_EN    = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic [REG_AW-1:0]   addr,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq_norm,
   output logic                irq_crit
);
   localparam int unsigned POS_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie between 1 and DATA_W");
   end
   if (DATA_W < 4) begin : g_bad_w
      $error("DATA_W must be at least 4");
   end
   if (VEC_SHIFT + POS_W > DATA_W) begin : g_bad_shift
      $error("VEC_SHIFT leaves no room for the scan position");
   end

   // Configuration state
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] cls_q;
   logic [NUM_SRC-1:0] pol_q;
   logic [NUM_SRC-1:0] trg_q;
   logic [DATA_W-1:0]  vcfg_q;

   logic [NUM_SRC-1:0] wr_src;
   logic [NUM_SRC-1:0] sw_clr;
   logic [NUM_SRC-1:0] sw_set;
   logic [NUM_SRC-1:0] act;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] st_q;
   logic [NUM_SRC-1:0] pend;
   logic [DATA_W-1:0]  vec_q;
   logic [DATA_W-1:0]  rd_mux;

   assign wr_src = wr_data[NUM_SRC-1:0];
   assign sw_clr = (wr_en && addr == OFS_STAT)  ? wr_src : '0;
   assign sw_set = (wr_en && addr == OFS_STSET) ? wr_src : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         cls_q  <= '0;
         pol_q  <= '0;
         trg_q  <= '0;
         vcfg_q <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_ENA:   en_q  <= wr_src;
            OFS_CLASS: cls_q <= wr_src;
            OFS_POL:   pol_q <= wr_src;
            OFS_TRIG:  trg_q <= wr_src;
            OFS_VCFG:  if (VEC_EN) vcfg_q <= wr_data & ~(DATA_W'(1) << VCFG_ZERO_BIT);
            default:   ;
         endcase
      end
   end

   cvi_src_cond #(.N(NUM_SRC)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_raw (irq_in),
      .pol     (pol_q),
      .act     (act),
      .rise    (rise)
   );

   cvi_status #(.N(NUM_SRC)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .rise   (rise),
      .trig   (trg_q),
      .sw_clr (sw_clr),
      .sw_set (sw_set),
      .st_q   (st_q)
   );

   assign pend = st_q & en_q;

   cvi_vector #(
      .N     (NUM_SRC),
      .W     (DATA_W),
      .SHIFT (VEC_SHIFT),
      .EN    (VEC_EN)
   ) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .crit  (pend & cls_q),
      .cfg   (vcfg_q),
      .vec_q (vec_q)
   );

   // Registered request outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_norm <= 1'b0;
         irq_crit <= 1'b0;
      end else begin
         irq_norm <= |(pend & ~cls_q);
         irq_crit <= |(pend & cls_q);
      end
   end

   // Read path
   always_comb begin
      case (addr)
         OFS_STAT, OFS_STSET: rd_mux = DATA_W'(st_q);
         OFS_ENA:             rd_mux = DATA_W'(en_q);
         OFS_CLASS:           rd_mux = DATA_W'(cls_q);
         OFS_POL:             rd_mux = DATA_W'(pol_q);
         OFS_TRIG:            rd_mux = DATA_W'(trg_q);
         OFS_MASKED:          rd_mux = DATA_W'(pend);
         OFS_VEC:             rd_mux = VEC_EN ? vec_q  : '0;
         OFS_VCFG:            rd_mux = VEC_EN ? vcfg_q : '0;
         default:             rd_mux = '0;
      endcase
   end

   assign rd_data = rd_en ? rd_mux : '0;
endmodule

// File: rtl/cvi_checker.sv
`timescale 1ns/1ps
// Property checker attached to crit_vec_intc
module cvi_checker
   import cvi_pkg::*;
#(
   parameter int unsigned N = 32,
   parameter int unsigned W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] addr,
   input logic              wr_en,
   input logic [W-1:0]      wr_data,
   input logic              rd_en,
   input logic [W-1:0]      rd_data,
   input logic              irq_norm,
   input logic              irq_crit,
   input logic [N-1:0]      st_q,
   input logic [N-1:0]      trg_q,
   input logic [N-1:0]      en_q,
   input logic [W-1:0]      vcfg_q,
   input logic [W-1:0]      vec_q
);
   logic [N-1:0] clr_v;
   assign clr_v = (wr_en && addr == OFS_STAT) ? wr_data[N-1:0] : '0;

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(st_q & trg_q) & ~$past(clr_v)) & ~st_q) == '0)); // R3

   AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_norm || irq_crit) |-> ($past(en_q) != '0)); // R6

   AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_crit |-> (vec_q == '0)); // R10

   AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_q & W'(3)) == '0); // R8

   AST_VCFG_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (vcfg_q & W'(2)) == '0); // R11

   always_comb begin
      if (rst_n && rd_en && addr == OFS_MASKED) begin
         AST_MASKED_SUBSET: assert ((rd_data & ~W'(en_q)) == '0); // R7
      end
   end
endmodule

bind crit_vec_intc cvi_checker #(.N(NUM_SRC), .W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .irq_norm (irq_norm),
   .irq_crit (irq_crit),
   .st_q     (st_q),
   .trg_q    (trg_q),
   .en_q     (en_q),
   .vcfg_q   (vcfg_q),
   .vec_q    (vec_q)
);

// File: tb/crit_vec_intc_test.sv
`timescale 1ns/1ps
module crit_vec_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '1;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq_norm;
   logic        irq_crit;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   crit_vec_intc uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .irq_norm (irq_norm),
      .irq_crit (irq_crit)
   );

   // All tasks start and end just after a falling edge
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1;
      d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic exp_reg(input string tag, input logic [3:0] a, input logic [31:0] e);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, e);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 9; a++) exp_reg($sformatf("R1 reg %0d", a), 4'(a), 32'h0);
      chk("R1 irq_norm", {31'b0, irq_norm}, 32'h0);
      chk("R1 irq_crit", {31'b0, irq_crit}, 32'h0);
   endtask

   task automatic t_polarity;
      irq_in[3] = 1'b0; step(2);
      exp_reg("R2 active-low asserted", 4'd0, 32'h8);
      irq_in[3] = 1'b1; step(2);
      exp_reg("R2 active-low released", 4'd0, 32'h0);
      irq_in = '0;
      wr(4'd4, 32'hFFFF_FFFF);
      step(2);
      exp_reg("R2 active-high idle", 4'd0, 32'h0);
      irq_in[3] = 1'b1; step(2);
      exp_reg("R2 active-high asserted", 4'd0, 32'h8);
      irq_in[3] = 1'b0; step(2);
   endtask

   task automatic t_level;
      irq_in[5] = 1'b1; irq_in[17] = 1'b1; step(2);
      exp_reg("R4 level follows", 4'd0, 32'h0002_0020);
      irq_in[5] = 1'b0; step(2);
      exp_reg("R4 level partial drop", 4'd0, 32'h0002_0000);
      irq_in[17] = 1'b0; step(2);
      exp_reg("R4 level all drop", 4'd0, 32'h0);
   endtask

   task automatic t_edge;
      irq_in[7] = 1'b1; step(1);
      irq_in[7] = 1'b0; step(3);
      exp_reg("R3 edge latched after pulse", 4'd0, 32'h80);
      wr(4'd0, 32'h80);
      exp_reg("R3 cleared by software", 4'd0, 32'h0);
      irq_in[7] = 1'b1; step(2);
      exp_reg("R3 edge latched held", 4'd0, 32'h80);
      wr(4'd0, 32'h80);
      step(2);
      exp_reg("R3 no relatch while held", 4'd0, 32'h0);
      irq_in[7] = 1'b0; step(1);
   endtask

   task automatic t_soft;
      wr(4'd1, 32'h0000_0300);
      exp_reg("R5 set via offset 1", 4'd0, 32'h300);
      exp_reg("R5 offset 1 reads status", 4'd1, 32'h300);
      wr(4'd0, 32'h100);
      exp_reg("R5 partial clear", 4'd0, 32'h200);
      wr(4'd0, 32'h200);
      exp_reg("R5 full clear", 4'd1, 32'h0);
   endtask

   task automatic t_outputs;
      wr(4'd2, 32'h0000_0C00);
      wr(4'd3, 32'h0000_0800);
      wr(4'd1, 32'h400);
      chk("R6 norm latency one cycle", {31'b0, irq_norm}, 32'h0);
      step(1);
      chk("R6 norm asserted", {31'b0, irq_norm}, 32'h1);
      chk("R6 crit quiet", {31'b0, irq_crit}, 32'h0);
      wr(4'd1, 32'h800);
      step(1);
      chk("R6 crit asserted", {31'b0, irq_crit}, 32'h1);
      wr(4'd0, 32'h400);
      step(1);
      chk("R6 norm dropped", {31'b0, irq_norm}, 32'h0);
      chk("R6 crit held", {31'b0, irq_crit}, 32'h1);
      wr(4'd1, 32'h1000);
      step(1);
      chk("R6 masked line silent", {31'b0, irq_norm}, 32'h0);
      wr(4'd0, 32'h1800);
      step(1);
      chk("R6 crit dropped", {31'b0, irq_crit}, 32'h0);
   endtask

   task automatic t_masked;
      wr(4'd1, 32'h1C00);
      exp_reg("R7 masked status", 4'd6, 32'h0C00);
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd7, 32'hFFFF_FFFF);
      step(1);
      exp_reg("R7 enable untouched", 4'd2, 32'h0C00);
      exp_reg("R7 status untouched", 4'd0, 32'h1C00);
      exp_reg("R7 masked unchanged", 4'd6, 32'h0C00);
      exp_reg("R7 vector unchanged", 4'd7, 32'h1600);
      wr(4'd0, 32'hFFFF_FFFF);
   endtask

   task automatic t_vec_up;
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd8, 32'h0001_0000);
      wr(4'd1, 32'h0010_0020);
      step(1);
      exp_reg("R8 up two pending", 4'd7, 32'h0001_0A00);
      chk("R8 no normal request", {31'b0, irq_norm}, 32'h0);
      wr(4'd0, 32'h20); step(1);
      exp_reg("R8 up line 20", 4'd7, 32'h0001_2800);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'h1); step(1);
      exp_reg("R8 up line 0 is base", 4'd7, 32'h0001_0000);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'h8000_0000); step(1);
      exp_reg("R8 up line 31", 4'd7, 32'h0001_3E00);
      wr(4'd0, 32'hFFFF_FFFF);
   endtask

   task automatic t_vec_down;
      wr(4'd8, 32'h0002_0001);
      wr(4'd1, 32'h0010_0020);
      step(1);
      exp_reg("R9 down two pending", 4'd7, 32'h0002_1600);
      wr(4'd0, 32'h0010_0000); step(1);
      exp_reg("R9 down line 5", 4'd7, 32'h0002_3400);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'h8000_0000); step(1);
      exp_reg("R9 down line 31 is base", 4'd7, 32'h0002_0000);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd3, 32'h0000_FFFF);
      wr(4'd1, 32'h0010_0008); step(1);
      exp_reg("R9 down skips normal class", 4'd7, 32'h0002_3800);
      chk("R9 normal line requests", {31'b0, irq_norm}, 32'h1);
   endtask

   task automatic t_vec_zero;
      wr(4'd0, 32'h8); step(1);
      exp_reg("R10 vector zero with base set", 4'd7, 32'h0);
      chk("R10 crit low", {31'b0, irq_crit}, 32'h0);
      wr(4'd0, 32'hFFFF_FFFF); step(1);
      exp_reg("R10 vector zero idle", 4'd7, 32'h0);
   endtask

   task automatic t_vcfg;
      wr(4'd8, 32'hFFFF_FFFF);
      exp_reg("R11 bit 1 forced low", 4'd8, 32'hFFFF_FFFD);
      wr(4'd8, 32'h2);
      exp_reg("R11 only bit 1 written", 4'd8, 32'h0);
   endtask

   task automatic t_unmapped;
      wr(4'd9, 32'hFFFF_FFFF);
      wr(4'd15, 32'hFFFF_FFFF);
      exp_reg("R12 offset 9", 4'd9, 32'h0);
      exp_reg("R12 offset 12", 4'd12, 32'h0);
      exp_reg("R12 offset 15", 4'd15, 32'h0);
      exp_reg("R12 enable untouched", 4'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_race;
      wr(4'd1, 32'h4000);
      irq_in[14] = 1'b1;
      wr(4'd0, 32'h4000);
      exp_reg("R13 rise beats clear", 4'd0, 32'h4000);
      irq_in[14] = 1'b0; step(1);
      wr(4'd0, 32'h4000);
      exp_reg("R13 clear alone works", 4'd0, 32'h0);
   endtask

   initial begin
      step(4);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_polarity();
      t_level();
      wr(4'd5, 32'hFFFF_FFFF);
      t_edge();
      t_soft();
      t_outputs();
      t_masked();
      t_vec_up();
      t_vec_down();
      t_vec_zero();
      t_vcfg();
      t_unmapped();
      t_race();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule